// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog for a processor subsystem. A bus-cycle enable drives a free-running binary prescaler of 2^PRESCALE_W steps. Each carry out of that prescaler is a tick. A second counter counts ticks against a factor picked by a two-bit rate field. When software stops servicing the block, the tick count reaches its terminal value and the block raises a one-clock reset request.

Software services the watchdog through a small write port. A write of 0x55 to the service address arms the clear logic. A later write of 0xAA to the same address clears the tick count. Any amount of other bus traffic may occur between the two writes.

The rate field sits at its own address. In normal operation it can be set once, early after reset, and is then frozen. The watchdog runs only if an enable input was high during reset. In test or boot modes, a hold-off input can mask the reset request until software drops it.

Top module: `keyed_watchdog`

## Requirements
- R1: `cfg_enable` is captured while `rst` is high. If it was low, `wd_reset` never pulses, and changing `cfg_enable` after reset has no effect until the next reset.
- R2: While `test_mode` and `hold_off` are both high, no request appears on `wd_reset`; an expiry in that state still clears the counters. With `test_mode` low, `hold_off` has no effect.
- R3: After reset `rate_sel` is 00. The rate field is taken from `wr_data[1:0]` on a write to address RATE_ADDR (default 0). Rate codes 00, 01, 10 and 11 select tick factors F of 1, 4, 16 and 64.
- R4: With `test_mode` low, only the first rate write is accepted, and only if it lands on one of the first LOCK_CYCLES bus cycles after reset (edges 1 to 64 with `bus_en` held high). Any later or second rate write leaves `rate_sel` unchanged. With `test_mode` high, rate writes are accepted at any time.
- R5: Counting from the end of reset, `wd_reset` goes high after bus cycle (F+1)·2^PRESCALE_W, so the timeout is never shorter than F prescaler periods and at most one period longer.
- R6: `wd_reset` is high for exactly one clock. Each expiry clears the prescaler and the tick count, so the next request follows after another (F+1)·2^PRESCALE_W bus cycles.
- R7: A write of 0x55 to address SVC_ADDR (default 1) arms the service logic. A later write of 0xAA to SVC_ADDR clears the tick count and disarms, without resetting the prescaler. Service writes of other values in between leave the armed state unchanged.
- R8: A write of 0xAA to SVC_ADDR while not armed has no effect. This includes a second 0xAA after a clear.
- R9: If a clearing 0xAA write and a terminal tick fall on the same clock, the clear wins and no request is issued.
- R10: The prescaler and the lock window advance only on clocks where `bus_en` is high.
- R11: Key values written to any address other than SVC_ADDR do not arm or clear the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus-cycle enable that advances the prescaler |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address (rate field or service key) |
| wr_data | input | 8 | Write data byte |
| cfg_enable | input | 1 | Watchdog enable, sampled during reset |
| test_mode | input | 1 | High in special test or boot modes |
| hold_off | input | 1 | Masks reset requests while `test_mode` is high |
| wd_reset | output | 1 | One-clock timeout reset request |
| rate_sel | output | 2 | Current rate field |

## Verification
The service clear and the terminal tick can fall on the same clock. The bench provokes this by arming early and then placing the 0xAA write exactly on the bus cycle where the expiry would fire (cycle 32 with a 16-step prescaler and rate 00). It judges the outcome by the absence of a pulse there and by the arrival of the next pulse at cycle 64, which confirms that the tick count was cleared rather than wrapped. It also checks the rate-lock boundary at write cycles 64 and 70, and runs with `bus_en` asserted on alternate clocks, where the first expiry moves to clock 64.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
  localparam int RATE_W = 2;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef logic [RATE_W-1:0] rate_t;

  // Each rate step multiplies the tick factor by four.
  function automatic int unsigned rate_factor(input rate_t r);
    return 32'd1 << (2 * int'(r));
  endfunction
endpackage

// File: rtl/kwd_prescaler.sv
`timescale 1ns/1ps
module kwd_prescaler #(
  parameter int W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic clr,
  output logic tick
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  // Carry out of the last stage.
  assign tick = step && (cnt_q == '1);
endmodule

// File: rtl/kwd_rate_reg.sv
`timescale 1ns/1ps
module kwd_rate_reg
  import kwd_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bus_en,
  input  logic  wr,
  input  rate_t wdata,
  input  logic  test_mode,
  output rate_t rate_q
);
  localparam int WIN_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(LOCK_CYCLES);

  logic [WIN_W-1:0] win_q;
  logic             done_q;
  logic             open;

  always_ff @(posedge clk) begin
    if (rst)                            win_q <= '0;
    else if (bus_en && win_q != WIN_END) win_q <= win_q + 1'b1;
  end

  assign open = test_mode || (!done_q && (win_q < WIN_END));

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      done_q <= 1'b0;
    end else if (wr && open) begin
      rate_q <= wdata;
      done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/kwd_service.sv
`timescale 1ns/1ps
module kwd_service
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       clear
);
  logic armed_q;

  assign clear = wr && armed_q && (wdata == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (wr) begin
      if (wdata == KEY_ARM)       armed_q <= 1'b1;
      else if (wdata == KEY_FIRE) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/kwd_timeout.sv
`timescale 1ns/1ps
module kwd_timeout #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             svc_clr,
  input  logic [CNT_W-1:0] factor,
  input  logic             mask,
  output logic             expire,
  output logic             pulse_q
);
  logic [CNT_W-1:0] cnt_q;

  // A service clear on the same clock takes precedence over expiry.
  assign expire = tick && (cnt_q == factor) && !svc_clr;

  always_ff @(posedge clk) begin
    if (rst || svc_clr || expire) cnt_q <= '0;
    else if (tick)                cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= expire && !mask;
  end
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int PRESCALE_W  = 15,
  parameter int LOCK_CYCLES = 64,
  parameter int ADDR_W      = 2,
  parameter int RATE_ADDR   = 0,
  parameter int SVC_ADDR    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cfg_enable,
  input  logic              test_mode,
  input  logic              hold_off,
  output logic              wd_reset,
  output logic [1:0]        rate_sel
);
  localparam int MAX_FACTOR = 1 << (2 * ((1 << RATE_W) - 1));
  localparam int CNT_W      = $clog2(MAX_FACTOR + 1);

  logic             run_q;
  logic             step, tick, expire, svc_clr;
  logic             wr_rate, wr_svc;
  rate_t            rate_q;
  logic [CNT_W-1:0] factor;

  always_ff @(posedge clk) begin
    if (rst) run_q <= cfg_enable;
  end

  assign step    = bus_en && run_q;
  assign wr_rate = wr_en && (wr_addr == ADDR_W'(RATE_ADDR));
  assign wr_svc  = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));
  assign factor  = CNT_W'(rate_factor(rate_q));

  kwd_prescaler #(.W(PRESCALE_W)) u_pre (
    .clk(clk), .rst(rst), .step(step), .clr(expire), .tick(tick)
  );

  kwd_rate_reg #(.LOCK_CYCLES(LOCK_CYCLES)) u_rate (
    .clk(clk), .rst(rst), .bus_en(bus_en), .wr(wr_rate),
    .wdata(rate_t'(wr_data[RATE_W-1:0])), .test_mode(test_mode), .rate_q(rate_q)
  );

  kwd_service u_svc (
    .clk(clk), .rst(rst), .wr(wr_svc), .wdata(wr_data), .clear(svc_clr)
  );

  kwd_timeout #(.CNT_W(CNT_W)) u_tmo (
    .clk(clk), .rst(rst), .tick(tick), .svc_clr(svc_clr), .factor(factor),
    .mask(test_mode && hold_off), .expire(expire), .pulse_q(wd_reset)
  );

  assign rate_sel = rate_q;
endmodule

// File: rtl/kwd_checker.sv
`timescale 1ns/1ps
module kwd_checker #(
  parameter int LOCK_CYCLES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_en,
  input logic       cfg_enable,
  input logic       test_mode,
  input logic       hold_off,
  input logic       wd_reset,
  input logic [1:0] rate_sel
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LW-1:0] LEND = LW'(LOCK_CYCLES);

  logic          en_c;
  logic [LW-1:0] bus_c;
  logic          late;

  always_ff @(posedge clk) begin
    if (rst) en_c <= cfg_enable;
  end

  always_ff @(posedge clk) begin
    if (rst)                            bus_c <= '0;
    else if (bus_en && bus_c != LEND)   bus_c <= bus_c + 1'b1;
  end

  assign late = (bus_c == LEND);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_c |-> !wd_reset); // R1
  AST_HOLD_OFF_MASK: assert property (@(posedge clk) disable iff (rst)
    (test_mode && hold_off) |=> !wd_reset); // R2
  AST_RATE_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rate_sel == 2'b00)); // R3
  AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && late) |=> $stable(rate_sel)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wd_reset |=> !wd_reset); // R6
endmodule

bind keyed_watchdog kwd_checker #(.LOCK_CYCLES(LOCK_CYCLES)) u_kwd_checker (
  .clk(clk), .rst(rst), .bus_en(bus_en), .cfg_enable(cfg_enable),
  .test_mode(test_mode), .hold_off(hold_off), .wd_reset(wd_reset),
  .rate_sel(rate_sel)
);

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
  localparam int PW = 4;
  localparam int P  = 1 << PW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cfg_enable = 1'b1;
  logic       test_mode = 1'b0;
  logic       hold_off = 1'b0;
  logic       wd_reset;
  logic [1:0] rate_sel;

  int n_chk = 0;
  int n_bad = 0;

  int         sch_n [4];
  logic [1:0] sch_a [4];
  logic [7:0] sch_d [4];
  int         nsch = 0;
  bit         half = 1'b0;

  always #5 clk = ~clk;

  keyed_watchdog #(.PRESCALE_W(PW)) i_keyed_watchdog (
    .clk(clk), .rst(rst), .bus_en(bus_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_enable(cfg_enable), .test_mode(test_mode),
    .hold_off(hold_off), .wd_reset(wd_reset), .rate_sel(rate_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic apply_reset(input bit en, input bit tm, input bit ho);
    @(negedge clk);
    rst = 1'b1; cfg_enable = en; test_mode = tm; hold_off = ho;
    bus_en = 1'b1; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nsch = 0; half = 1'b0;
  endtask

  task automatic sched(input int at, input logic [1:0] a, input logic [7:0] d);
    sch_n[nsch] = at; sch_a[nsch] = a; sch_d[nsch] = d;
    nsch++;
  endtask

  // Runs from a negedge; returns the edge count at which wd_reset was seen, 0 if none.
  task automatic run_until_pulse(input int max, output int got);
    got = 0;
    for (int n = 1; n <= max; n++) begin
      bus_en = half ? (n % 2 == 0) : 1'b1;
      wr_en = 1'b0;
      for (int k = 0; k < nsch; k++)
        if (sch_n[k] == n) begin
          wr_en = 1'b1; wr_addr = sch_a[k]; wr_data = sch_d[k];
        end
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      if (wd_reset) begin got = n; break; end
    end
    bus_en = 1'b1;
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic write1(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state();
    apply_reset(1'b1, 1'b0, 1'b0);
    check(rate_sel == 2'b00, "R3 reset rate", rate_sel, 0);
    check(wd_reset == 1'b0, "R6 reset request low", wd_reset, 0);
  endtask

  task automatic t_rates();
    int got;
    for (int r = 0; r < 4; r++) begin
      apply_reset(1'b1, 1'b0, 1'b0);
      sched(1, 2'd0, 8'(r));
      run_until_pulse(1200, got);
      check(got == ((1 << (2 * r)) + 1) * P, "R3 R5 timeout per rate", got, ((1 << (2 * r)) + 1) * P);
    end
  endtask

  task automatic t_repeat();
    int got;
    apply_reset(1'b1, 1'b0, 1'b0);
    run_until_pulse(100, got);
    check(got == 2 * P, "R5 first expiry", got, 2 * P);
    @(posedge clk); @(negedge clk);
    check(wd_reset == 1'b0, "R6 pulse width", wd_reset, 0);
    run_until_pulse(100, got);
    check(got == 2 * P - 1, "R6 period after expiry", got, 2 * P - 1);
  endtask

  task automatic t_lock();
    apply_reset(1'b1, 1'b0, 1'b0);
    idle(63);
    write1(2'd0, 8'h02);
    check(rate_sel == 2'd2, "R4 write on cycle 64 accepted", rate_sel, 2);
    write1(2'd0, 8'h01);
    check(rate_sel == 2'd2, "R4 second write ignored", rate_sel, 2);
    apply_reset(1'b1, 1'b0, 1'b0);
    idle(69);
    write1(2'd0, 8'h03);
    check(rate_sel == 2'd0, "R4 late write ignored", rate_sel, 0);
    apply_reset(1'b1, 1'b1, 1'b1);
    idle(100);
    write1(2'd0, 8'h02);
    check(rate_sel == 2'd2, "R4 test mode late write", rate_sel, 2);
    write1(2'd0, 8'h03);
    check(rate_sel == 2'd3, "R4 test mode rewrite", rate_sel, 3);
  endtask

  task automatic t_enable();
    int got;
    apply_reset(1'b0, 1'b0, 1'b0);
    run_until_pulse(200, got);
    check(got == 0, "R1 disabled no request", got, 0);
    cfg_enable = 1'b1;
    run_until_pulse(200, got);
    check(got == 0, "R1 enable change ignored", got, 0);
  endtask

  task automatic t_hold();
    int got;
    apply_reset(1'b1, 1'b1, 1'b1);
    run_until_pulse(200, got);
    check(got == 0, "R2 held off", got, 0);
    hold_off = 1'b0;
    run_until_pulse(100, got);
    check(got == 24, "R2 release", got, 24);
    apply_reset(1'b1, 1'b0, 1'b1);
    run_until_pulse(100, got);
    check(got == 2 * P, "R2 normal mode ignores hold", got, 2 * P);
  endtask

  task automatic t_service();
    int got;
    apply_reset(1'b1, 1'b0, 1'b0);
    sched(10, 2'd1, 8'h55); sched(20, 2'd1, 8'hAA);
    run_until_pulse(200, got);
    check(got == 48, "R7 keyed clear", got, 48);
    apply_reset(1'b1, 1'b0, 1'b0);
    sched(5, 2'd1, 8'h55); sched(12, 2'd1, 8'h12); sched(20, 2'd1, 8'hAA);
    run_until_pulse(200, got);
    check(got == 48, "R7 other value keeps arm", got, 48);
    apply_reset(1'b1, 1'b0, 1'b0);
    sched(20, 2'd1, 8'hAA);
    run_until_pulse(200, got);
    check(got == 32, "R8 unarmed fire", got, 32);
    apply_reset(1'b1, 1'b0, 1'b0);
    sched(5, 2'd1, 8'h55); sched(10, 2'd1, 8'hAA); sched(20, 2'd1, 8'hAA);
    run_until_pulse(200, got);
    check(got == 32, "R8 second fire", got, 32);
    apply_reset(1'b1, 1'b0, 1'b0);
    sched(5, 2'd1, 8'h55); sched(20, 2'd2, 8'hAA);
    run_until_pulse(200, got);
    check(got == 32, "R11 wrong address", got, 32);
  endtask

  task automatic t_collide();
    int got;
    apply_reset(1'b1, 1'b0, 1'b0);
    sched(10, 2'd1, 8'h55); sched(32, 2'd1, 8'hAA);
    run_until_pulse(200, got);
    check(got == 64, "R9 clear beats expiry", got, 64);
  endtask

  task automatic t_bus_gate();
    int got;
    apply_reset(1'b1, 1'b0, 1'b0);
    half = 1'b1;
    run_until_pulse(200, got);
    check(got == 4 * P, "R10 bus enable gating", got, 4 * P);
  endtask

  initial begin
    t_reset_state();
    t_rates();
    t_repeat();
    t_lock();
    t_enable();
    t_hold();
    t_service();
    t_collide();
    t_bus_gate();
    finish_run();
  end

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule